// File: doc/BRIEF.md
# Reset and Power-Down Sequencer

This block orders the reset and power-down behaviour of a small controller system. It watches an already synchronized active-low reset pin, software and watchdog reset requests, and a non-maskable interrupt line. Any qualified reset source starts an internal reset sequence of fixed length. When the bidirectional option is enabled, the block also pulls the reset pin low for the whole sequence, whatever the source.

An active-low indication output goes low with every reset. It stays low after the sequence has ended, until software reports that initialization is complete. A falling edge on the interrupt line produces a one-cycle trap request. A power-down request is accepted or dropped depending on a configuration bit and on the level of the interrupt line at the moment of the request.

Top module: `rst_pd_sequencer`

## Requirements
- R1: A hardware reset starts only after `extRstN` has been sampled low on QUAL_CYCLES (default 4) consecutive clock edges. `sysRst` rises at the edge that takes the last of those samples. A shorter low pulse has no effect.
- R2: A reset source sampled at an edge (a qualified pin, `swRstReq` high or `wdtRstReq` high) makes `sysRst` high for exactly SEQ_CYCLES (default 16) cycles, counted from that edge.
- R3: A new reset source that arrives while a sequence is running restarts the full SEQ_CYCLES count from the edge at which it is sampled.
- R4: `rstIndN` goes low at the same edge as `sysRst` for every source. It stays low after `sysRst` falls, and it returns high only at an edge where `initDone` is high and no sequence is running. `initDone` has no effect while `sysRst` is high.
- R5: When `bidirRstEn` is 1, `rstPinPullDn` is high in every cycle in which `sysRst` is high, for all reset sources. When `bidirRstEn` is 0, `rstPinPullDn` is 0. While the pin is being pulled low, its level is not counted toward R1.
- R6: A high-to-low change of `nmiPin` between two edges makes `nmiTrap` high for the single cycle after the second edge. A pin that stays low produces no further trap.
- R7: With `pdCfg` = 0, a `pdReq` sampled at an edge sets `pdActive` if `nmiPin` is low at that edge. If `nmiPin` is high, the request is dropped and `pdActive` stays 0.
- R8: With `pdCfg` = 1, a `pdReq` sets `pdActive` regardless of `nmiPin`.
- R9: Any reset source clears `pdActive` at the edge where it is sampled. A `pdReq` that arrives while `sysRst` is high is ignored.
- R10: While `porN` is low, `sysRst` = 1, `rstIndN` = 0, `pdActive` = 0 and `nmiTrap` = 0. After `porN` is released, a full SEQ_CYCLES sequence runs.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset of the sequencer, active low |
| extRstN | input | 1 | Synchronized external reset pin level, active low |
| swRstReq | input | 1 | Software reset request |
| wdtRstReq | input | 1 | Watchdog reset request |
| initDone | input | 1 | End-of-initialization strobe |
| pdReq | input | 1 | Power-down request strobe |
| nmiPin | input | 1 | Non-maskable interrupt line level |
| bidirRstEn | input | 1 | Drive the reset pin low during every sequence |
| pdCfg | input | 1 | 1: power-down unconditional; 0: gated by a low `nmiPin` |
| sysRst | output | 1 | Internal reset, active high |
| rstIndN | output | 1 | Reset indication, active low |
| rstPinPullDn | output | 1 | Open-drain pull-down enable for the reset pin |
| nmiTrap | output | 1 | One-cycle interrupt trap request |
| pdActive | output | 1 | Power-down state flag |

## Verification
Every result appears one edge after the stimulus that causes it:
- `sysRst`, `rstIndN`, `pdActive` and `nmiTrap` all change at that edge.
- `rstPinPullDn` follows `sysRst` combinationally.
- A pin reset appears only at the QUAL_CYCLES-th consecutive low sample.

The end of a sequence is checked on both sides of the boundary: `sysRst` must still be high SEQ_CYCLES-1 edges after the trigger, and must be low one edge later. Inputs change and outputs are sampled 1 ns after a rising edge, so each check reads the state produced by one known edge.

// File: rtl/rstpd_pkg.sv
package rstpd_pkg;
  // Strobes from the control module to the datapath module
  typedef struct packed {
    logic loadSeq;   // restart the reset-sequence counter
    logic maskPin;   // reset pin is being driven low by this block
  } ctrlStrobes_t;

  // Status from the datapath module to the control module
  typedef struct packed {
    logic hwQual;    // pin low long enough to count as a reset
    logic seqActive; // reset sequence running
    logic nmiFall;   // falling edge seen on the interrupt line
  } dpStatus_t;
endpackage

// File: rtl/rstpd_datapath.sv
module rstpd_datapath
  import rstpd_pkg::*;
#(
  parameter int QUAL_CYCLES = 4,
  parameter int SEQ_CYCLES  = 16
) (
  input  logic         clk,
  input  logic         porN,
  input  logic         extRstN,
  input  logic         nmiPin,
  input  ctrlStrobes_t strobes,
  output dpStatus_t    status
);
  localparam int QUAL_W = $clog2(QUAL_CYCLES + 1);
  localparam int SEQ_W  = $clog2(SEQ_CYCLES + 1);
  localparam logic [QUAL_W-1:0] QUAL_LAST = QUAL_W'(QUAL_CYCLES - 1);
  localparam logic [SEQ_W-1:0]  SEQ_LOAD  = SEQ_W'(SEQ_CYCLES);

  logic [QUAL_W-1:0] lowCnt;
  logic [SEQ_W-1:0]  seqCnt;
  logic              nmiPrev;
  logic              pinLow;

  assign pinLow = !extRstN && !strobes.maskPin;

  // Count consecutive low samples of the reset pin, saturating at the limit
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      lowCnt <= '0;
    end else if (!pinLow) begin
      lowCnt <= '0;
    end else if (lowCnt != QUAL_LAST) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // Down-counter for the length of the reset sequence
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      seqCnt <= SEQ_LOAD;
    end else if (strobes.loadSeq) begin
      seqCnt <= SEQ_LOAD;
    end else if (seqCnt != '0) begin
      seqCnt <= seqCnt - 1'b1;
    end
  end

  // Previous level of the interrupt line, for edge detection
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) nmiPrev <= 1'b0;
    else       nmiPrev <= nmiPin;
  end

  assign status.hwQual    = pinLow && (lowCnt == QUAL_LAST);
  assign status.seqActive = (seqCnt != '0);
  assign status.nmiFall   = nmiPrev && !nmiPin;
endmodule

// File: rtl/rstpd_control.sv
module rstpd_control
  import rstpd_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         swRstReq,
  input  logic         wdtRstReq,
  input  logic         initDone,
  input  logic         pdReq,
  input  logic         nmiPin,
  input  logic         bidirRstEn,
  input  logic         pdCfg,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         indLow,
  output logic         trapReg,
  output logic         pdReg
);
  logic anyReset;
  logic pdAccept;

  assign anyReset = status.hwQual || swRstReq || wdtRstReq;
  assign pdAccept = pdReq && !status.seqActive && (pdCfg || !nmiPin);

  assign strobes.loadSeq = anyReset;
  assign strobes.maskPin = bidirRstEn && status.seqActive;

  // Reset indication: set by any reset, cleared by end-of-initialization
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      indLow <= 1'b1;
    end else if (anyReset) begin
      indLow <= 1'b1;
    end else if (initDone && !status.seqActive) begin
      indLow <= 1'b0;
    end
  end

  // Power-down flag: a reset takes priority over a request
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pdReg <= 1'b0;
    end else if (anyReset) begin
      pdReg <= 1'b0;
    end else if (pdAccept) begin
      pdReg <= 1'b1;
    end
  end

  // One-cycle trap request on a falling edge of the interrupt line
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) trapReg <= 1'b0;
    else       trapReg <= status.nmiFall;
  end
endmodule

// File: rtl/rst_pd_sequencer.sv
module rst_pd_sequencer
  import rstpd_pkg::*;
#(
  parameter int QUAL_CYCLES = 4,
  parameter int SEQ_CYCLES  = 16
) (
  input  logic clk,
  input  logic porN,
  input  logic extRstN,
  input  logic swRstReq,
  input  logic wdtRstReq,
  input  logic initDone,
  input  logic pdReq,
  input  logic nmiPin,
  input  logic bidirRstEn,
  input  logic pdCfg,
  output logic sysRst,
  output logic rstIndN,
  output logic rstPinPullDn,
  output logic nmiTrap,
  output logic pdActive
);
  ctrlStrobes_t strobes;
  dpStatus_t    status;
  logic         indLow;

  rstpd_datapath #(
    .QUAL_CYCLES(QUAL_CYCLES),
    .SEQ_CYCLES (SEQ_CYCLES)
  ) dp_i (
    .clk     (clk),
    .porN    (porN),
    .extRstN (extRstN),
    .nmiPin  (nmiPin),
    .strobes (strobes),
    .status  (status)
  );

  rstpd_control ctl_i (
    .clk        (clk),
    .porN       (porN),
    .swRstReq   (swRstReq),
    .wdtRstReq  (wdtRstReq),
    .initDone   (initDone),
    .pdReq      (pdReq),
    .nmiPin     (nmiPin),
    .bidirRstEn (bidirRstEn),
    .pdCfg      (pdCfg),
    .status     (status),
    .strobes    (strobes),
    .indLow     (indLow),
    .trapReg    (nmiTrap),
    .pdReg      (pdActive)
  );

  assign sysRst       = status.seqActive;
  assign rstIndN      = !indLow;
  assign rstPinPullDn = strobes.maskPin;
endmodule

// File: rtl/rst_pd_checker.sv
module rst_pd_checker (
  input logic clk,
  input logic porN,
  input logic extRstN,
  input logic swRstReq,
  input logic wdtRstReq,
  input logic initDone,
  input logic pdReq,
  input logic nmiPin,
  input logic bidirRstEn,
  input logic pdCfg,
  input logic sysRst,
  input logic rstIndN,
  input logic rstPinPullDn,
  input logic nmiTrap,
  input logic pdActive
);
  // R2: a software or watchdog request starts the sequence at the next edge
  assert_req_starts_R2: assert property (@(posedge clk) disable iff (!porN)
    (swRstReq || wdtRstReq) |=> sysRst);

  // R4: the indication is low for as long as the sequence runs
  assert_ind_low_in_seq_R4: assert property (@(posedge clk) disable iff (!porN)
    sysRst |-> !rstIndN);

  // R4: the indication rises only after an end-of-initialization strobe
  assert_ind_release_R4: assert property (@(posedge clk) disable iff (!porN)
    $rose(rstIndN) |-> ($past(initDone) && !$past(sysRst)));

  // R6: a trap request lasts a single cycle
  assert_trap_single_R6: assert property (@(posedge clk) disable iff (!porN)
    nmiTrap |=> !nmiTrap);

  // R7: a gated request with the interrupt line high is dropped
  assert_pd_gated_R7: assert property (@(posedge clk) disable iff (!porN)
    (pdReq && !pdCfg && nmiPin && !pdActive) |=> !pdActive);

  // R9: no power-down state during a reset sequence
  assert_pd_clear_R9: assert property (@(posedge clk) disable iff (!porN)
    sysRst |-> !pdActive);

  // R5: the pull-down is never active without the option enabled
  assert_pull_needs_en_R5: assert property (@(posedge clk) disable iff (!porN)
    rstPinPullDn |-> (bidirRstEn && sysRst));
endmodule

bind rst_pd_sequencer rst_pd_checker chk_i (.*);

// File: tb/rst_pd_sequencer_tb_top.sv
module rst_pd_sequencer_tb_top;
  localparam int QUAL = 4;
  localparam int SEQ  = 16;

  logic clk = 1'b0;
  logic porN, extRstN, swRstReq, wdtRstReq, initDone, pdReq, nmiPin;
  logic bidirRstEn, pdCfg;
  logic sysRst, rstIndN, rstPinPullDn, nmiTrap, pdActive;
  int   checks = 0;
  int   errors = 0;

  always #2 clk = ~clk;

  rst_pd_sequencer #(.QUAL_CYCLES(QUAL), .SEQ_CYCLES(SEQ)) dut_i (
    .clk(clk), .porN(porN), .extRstN(extRstN), .swRstReq(swRstReq),
    .wdtRstReq(wdtRstReq), .initDone(initDone), .pdReq(pdReq),
    .nmiPin(nmiPin), .bidirRstEn(bidirRstEn), .pdCfg(pdCfg),
    .sysRst(sysRst), .rstIndN(rstIndN), .rstPinPullDn(rstPinPullDn),
    .nmiTrap(nmiTrap), .pdActive(pdActive)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, actual, expected);
    end
  endtask

  task automatic release_init();
    initDone = 1'b1; tick(1); initDone = 1'b0;
  endtask

  task automatic test_por();
    check("R10", "sysRst in por", sysRst, 1'b1);
    check("R10", "rstIndN in por", rstIndN, 1'b0);
    check("R10", "pdActive in por", pdActive, 1'b0);
    check("R10", "nmiTrap in por", nmiTrap, 1'b0);
    @(posedge clk); #1; porN = 1'b1;
    tick(SEQ - 1);
    check("R10", "sysRst before end", sysRst, 1'b1);
    tick(1);
    check("R10", "sysRst after end", sysRst, 1'b0);
    check("R4", "rstIndN held after seq", rstIndN, 1'b0);
    release_init();
    check("R4", "rstIndN after initDone", rstIndN, 1'b1);
  endtask

  task automatic test_sw_bidir();
    bidirRstEn = 1'b1;
    swRstReq = 1'b1; tick(1); swRstReq = 1'b0;
    check("R2", "sysRst after sw req", sysRst, 1'b1);
    check("R4", "rstIndN after sw req", rstIndN, 1'b0);
    check("R5", "pull-down on sw reset", rstPinPullDn, 1'b1);
    extRstN = 1'b0; // pin low while the block drives it; must not qualify
    tick(7);
    release_init(); // ignored during the sequence
    check("R4", "initDone ignored in seq", rstIndN, 1'b0);
    tick(SEQ - 9);
    check("R2", "sysRst last cycle", sysRst, 1'b1);
    check("R5", "pull-down last cycle", rstPinPullDn, 1'b1);
    extRstN = 1'b1;
    tick(1);
    check("R2", "sysRst ended", sysRst, 1'b0);
    check("R5", "pin masked during pull-down", sysRst, 1'b0);
    check("R5", "pull-down released", rstPinPullDn, 1'b0);
    check("R4", "rstIndN still low", rstIndN, 1'b0);
    release_init();
    check("R4", "rstIndN released", rstIndN, 1'b1);
    bidirRstEn = 1'b0;
  endtask

  task automatic test_hw_qual();
    extRstN = 1'b0; tick(QUAL - 1); extRstN = 1'b1;
    tick(1);
    check("R1", "short pulse ignored", sysRst, 1'b0);
    check("R1", "short pulse no indication", rstIndN, 1'b1);
    extRstN = 1'b0; tick(QUAL - 1);
    check("R1", "not yet qualified", sysRst, 1'b0);
    tick(1); extRstN = 1'b1;
    check("R1", "qualified reset", sysRst, 1'b1);
    check("R5", "no pull-down when disabled", rstPinPullDn, 1'b0);
    tick(SEQ - 1);
    check("R2", "hw seq last cycle", sysRst, 1'b1);
    tick(1);
    check("R2", "hw seq ended", sysRst, 1'b0);
    release_init();
  endtask

  task automatic test_restart();
    swRstReq = 1'b1; tick(1); swRstReq = 1'b0;
    tick(7);
    wdtRstReq = 1'b1; tick(1); wdtRstReq = 1'b0;
    tick(SEQ - 1);
    check("R3", "restarted seq still running", sysRst, 1'b1);
    tick(1);
    check("R3", "restarted seq ended", sysRst, 1'b0);
    check("R4", "wdt indication low", rstIndN, 1'b0);
    release_init();
  endtask

  task automatic test_nmi();
    nmiPin = 1'b0; tick(1);
    check("R6", "trap on falling edge", nmiTrap, 1'b1);
    tick(1);
    check("R6", "trap one cycle", nmiTrap, 1'b0);
    tick(5);
    check("R6", "steady low no trap", nmiTrap, 1'b0);
    nmiPin = 1'b1; tick(1);
    check("R6", "rising edge no trap", nmiTrap, 1'b0);
  endtask

  task automatic test_pd();
    pdCfg = 1'b0; nmiPin = 1'b1;
    pdReq = 1'b1; tick(1); pdReq = 1'b0;
    check("R7", "request dropped with nmi high", pdActive, 1'b0);
    nmiPin = 1'b0;
    pdReq = 1'b1; tick(1); pdReq = 1'b0;
    check("R7", "request accepted with nmi low", pdActive, 1'b1);
    swRstReq = 1'b1; tick(1); swRstReq = 1'b0;
    check("R9", "reset clears power-down", pdActive, 1'b0);
    pdCfg = 1'b1;
    pdReq = 1'b1; tick(1); pdReq = 1'b0;
    check("R9", "request ignored in seq", pdActive, 1'b0);
    tick(SEQ);
    release_init();
    nmiPin = 1'b1; tick(1);
    pdReq = 1'b1; tick(1); pdReq = 1'b0;
    check("R8", "unconditional power-down", pdActive, 1'b1);
    wdtRstReq = 1'b1; tick(1); wdtRstReq = 1'b0;
    check("R9", "wdt clears power-down", pdActive, 1'b0);
    tick(SEQ);
    release_init();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    porN = 1'b0; extRstN = 1'b1; swRstReq = 1'b0; wdtRstReq = 1'b0;
    initDone = 1'b0; pdReq = 1'b0; nmiPin = 1'b1;
    bidirRstEn = 1'b0; pdCfg = 1'b0;
    tick(2);
    test_por();
    test_sw_bidir();
    test_hw_qual();
    test_restart();
    test_nmi();
    test_pd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule